// File: doc/BRIEF.md
# Lockable Analog Trim Register Bank

This block holds the trim settings that tune a set of analog circuits after fabrication. Four byte-wide registers sit in a 4-byte window of a local register bus. Boot firmware copies calibration bytes from non-volatile storage into them, using either byte or 16-bit word accesses. Each stored byte drives a parallel trim output straight into the analog domain.

One register carries a sleep-bandgap trim field with a sticky lock. While the lock is clear, firmware may step the 3-bit code as often as it likes to find the best setting. A single write that carries the chosen code, the field's enable bit and the lock bit together applies the code and freezes the field. After that, only a reset can change the code, the enable bit or the lock bit.

Register contents survive a low-power indication unchanged. Only the synchronous reset brings them back to their defaults.

Top module: `trim_bank`

## Requirements
- R1: The registers answer at byte addresses BASE+0, BASE+1, BASE+2 and BASE+3 (0xF0 to 0xF3 by default). A byte access (bus_word=0) reads or writes one register. A write to any address outside the window changes nothing, and a read there returns zero.
- R2: The register at BASE+2 is reserved. It reads as 0x00 and ignores writes.
- R3: Reset loads these defaults: 0x5A at BASE+0, 0x14 at BASE+1 (code 4, plain bits 010, enable 0, lock 0), 0x00 at BASE+2 and 0xA5 at BASE+3.
- R4: The lowpwr_i input has no effect on register contents or on the trim outputs.
- R5: A word access (bus_word=1) ignores address bit 0. It writes bus_wdata[7:0] to the even register of the pair and bus_wdata[15:8] to the odd one. This includes the pair BASE+2/BASE+3, where the reserved byte is dropped and BASE+3 is written.
- R6: The register at BASE+1 is laid out as bit7 lock, bit6 enable, bits[5:3] plain trim, bits[2:0] sleep-bandgap code. While the field is unlocked, every write loads the enable bit from data bit 6. The code is loaded from data bits[2:0] only when data bit 6 is 1.
- R7: The lock bit becomes 1 only through a write with data bits 7 and 6 both 1. The same write also loads the code. A write with bit 7 set and bit 6 clear leaves the lock at 0.
- R8: Once locked, the lock, enable and code bits ignore every write until reset. Bits[5:3] stay writable. Reset clears the lock.
- R9: When bus_rd is high at a clock edge, bus_rvalid is 1 in the following cycle and bus_rdata holds the contents as they stood before any write in that same cycle. A byte read returns {0x00, register}. A word read returns {odd register, even register}.
- R10: trim0_o, trim1_o and trim3_o always equal the registers at BASE+0, BASE+1 and BASE+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lowpwr_i | input | 1 | Low-power indication (contents retained) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| trim0_o | output | 8 | Trim byte at BASE+0 |
| trim1_o | output | 8 | Trim byte at BASE+1, lock field included |
| trim3_o | output | 8 | Trim byte at BASE+3 |

## Verification
The hardest state to reach is a locked field whose neighbouring plain bits must still respond to writes. A near-miss write is just as hard: lock bit set but enable clear, which must leave the field open. The stimulus table walks the field through these steps in order:
- free code changes with enable set;
- a write with enable clear;
- the near-miss lock attempt;
- the real lock;
- rejected retries;
- a plain-bit write after the lock.

Every step is read back through the bus. A final reset and write show that the lock has been released.

// File: rtl/trim_bank_pkg.sv
package trim_bank_pkg;
  localparam int NREG     = 4;
  localparam int LOCK_IDX = 1;
  localparam int RSVD_IDX = 2;
  localparam int CODE_W   = 3;
  localparam int B_LOCK   = 7;
  localparam int B_EN     = 6;
  localparam int MID_LO   = CODE_W;
  localparam int MID_HI   = B_EN - 1;
  localparam int MID_W    = MID_HI - MID_LO + 1;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/trim_addr_dec.sv
module trim_addr_dec
  import trim_bank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'hF0
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wr,
  input  logic                   word,
  input  logic [15:0]            wdata,
  output logic [NREG-1:0]        we,
  output logic [NREG-1:0][7:0]   wbyte
);
  logic       hit;
  logic [1:0] idx;

  always_comb begin
    hit   = (addr[ADDR_W-1:2] == BASE[ADDR_W-1:2]);
    idx   = addr[1:0];
    we    = '0;
    wbyte = '0;
    if (wr && hit) begin
      if (word) begin
        we[{idx[1], 1'b0}]    = 1'b1;
        wbyte[{idx[1], 1'b0}] = wdata[7:0];
        we[{idx[1], 1'b1}]    = 1'b1;
        wbyte[{idx[1], 1'b1}] = wdata[15:8];
      end else begin
        we[idx]    = 1'b1;
        wbyte[idx] = wdata[7:0];
      end
    end
  end
endmodule

// File: rtl/trim_lock_field.sv
module trim_lock_field #(
  parameter int CODE_W = 3,
  parameter logic [CODE_W-1:0] CODE_DEF = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              wr_lock,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  output logic              lock_q,
  output logic              en_q,
  output logic [CODE_W-1:0] code_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      en_q   <= 1'b0;
      code_q <= CODE_DEF;
    end else if (we && !lock_q) begin
      en_q   <= wr_en;
      lock_q <= wr_lock && wr_en;
      if (wr_en) code_q <= wr_code;
    end
  end

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);
  p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> ($stable(code_q) && $stable(en_q)));
  p_lock_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> en_q);
  p_code_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(code_q));
endmodule

// File: rtl/trim_bank.sv
module trim_bank
  import trim_bank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'hF0,
  parameter logic [7:0] DEF0 = 8'h5A,
  parameter logic [MID_W-1:0] DEF1_MID = 3'b010,
  parameter logic [CODE_W-1:0] DEF1_CODE = 3'd4,
  parameter logic [7:0] DEF3 = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lowpwr_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_word,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic [7:0]        trim0_o,
  output logic [7:0]        trim1_o,
  output logic [7:0]        trim3_o
);
  localparam logic [ADDR_W-1:0] RSVD_ADDR = BASE + ADDR_W'(RSVD_IDX);

  logic [NREG-1:0]      we;
  logic [NREG-1:0][7:0] wbyte;
  byte_t                regs [NREG];

  trim_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .word(bus_word), .wdata(bus_wdata),
    .we(we), .wbyte(wbyte)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == LOCK_IDX) begin : g_lock
      logic              lk, en;
      logic [CODE_W-1:0] code;
      logic [MID_W-1:0]  mid_q;
      trim_lock_field #(.CODE_W(CODE_W), .CODE_DEF(DEF1_CODE)) u_field (
        .clk(clk), .rst(rst), .we(we[i]),
        .wr_lock(wbyte[i][B_LOCK]), .wr_en(wbyte[i][B_EN]),
        .wr_code(wbyte[i][CODE_W-1:0]),
        .lock_q(lk), .en_q(en), .code_q(code)
      );
      always_ff @(posedge clk) begin
        if (rst)        mid_q <= DEF1_MID;
        else if (we[i]) mid_q <= wbyte[i][MID_HI:MID_LO];
      end
      assign regs[i] = {lk, en, mid_q, code};
    end else if (i == RSVD_IDX) begin : g_rsvd
      logic unused_rsvd;
      assign unused_rsvd = ^{we[i], wbyte[i]};
      assign regs[i] = 8'h00;
    end else begin : g_plain
      localparam logic [7:0] DEF = (i == 0) ? DEF0 : DEF3;
      byte_t q;
      always_ff @(posedge clk) begin
        if (rst)        q <= DEF;
        else if (we[i]) q <= wbyte[i];
      end
      assign regs[i] = q;
    end
  end

  logic       rd_hit;
  logic [1:0] rd_idx;
  logic [15:0] rd_val;
  always_comb begin
    rd_hit = (bus_addr[ADDR_W-1:2] == BASE[ADDR_W-1:2]);
    rd_idx = bus_addr[1:0];
    rd_val = '0;
    if (rd_hit) begin
      if (bus_word) rd_val = {regs[{rd_idx[1], 1'b1}], regs[{rd_idx[1], 1'b0}]};
      else          rd_val = {8'h00, regs[rd_idx]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_val;
    end
  end

  assign trim0_o = regs[0];
  assign trim1_o = regs[LOCK_IDX];
  assign trim3_o = regs[3];

  p_retain_r4: assert property (@(posedge clk) disable iff (rst)
    (lowpwr_i && !bus_wr) |=> ($stable(trim0_o) && $stable(trim1_o) && $stable(trim3_o)));
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_word && bus_addr == RSVD_ADDR) |=> (bus_rdata == 16'h0000));
  p_rvalid_r9: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
endmodule

// File: tb/trim_bank_tb.sv
module trim_bank_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lowpwr_i = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_word = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic bus_rvalid;
  logic [7:0] trim0_o, trim1_o, trim3_o;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  trim_bank u_dut (
    .clk(clk), .rst(rst), .lowpwr_i(lowpwr_i), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .trim0_o(trim0_o), .trim1_o(trim1_o), .trim3_o(trim3_o)
  );

  // {read, word, addr, data}: read -> data is expected value
  localparam int NV = 30;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'hF0, 16'h005A},  // R3 default
    {1'b1, 1'b0, 8'hF1, 16'h0014},  // R3 default
    {1'b1, 1'b0, 8'hF2, 16'h0000},  // R3 R2
    {1'b1, 1'b0, 8'hF3, 16'h00A5},  // R3
    {1'b1, 1'b1, 8'hF0, 16'h145A},  // R9 word read
    {1'b0, 1'b0, 8'hF0, 16'h003C},  // R1 byte write
    {1'b1, 1'b0, 8'hF0, 16'h003C},  // R1
    {1'b0, 1'b0, 8'hF2, 16'h00FF},  // R2 write reserved
    {1'b1, 1'b1, 8'hF2, 16'hA500},  // R2
    {1'b0, 1'b1, 8'hF2, 16'h7700},  // R5 word over reserved pair
    {1'b1, 1'b1, 8'hF2, 16'h7700},  // R5
    {1'b0, 1'b1, 8'hF1, 16'h2811},  // R5 odd addr aligned down, R6 en=0
    {1'b1, 1'b1, 8'hF0, 16'h2C11},  // R5 R6 code kept
    {1'b0, 1'b0, 8'hF1, 16'h0043},  // R6 en=1 code 3
    {1'b1, 1'b0, 8'hF1, 16'h0043},  // R6
    {1'b0, 1'b0, 8'hF1, 16'h0086},  // R7 lock without enable
    {1'b1, 1'b0, 8'hF1, 16'h0003},  // R7 lock stays clear
    {1'b0, 1'b0, 8'hF1, 16'h0045},  // R6 retry code 5
    {1'b1, 1'b0, 8'hF1, 16'h0045},  // R6
    {1'b0, 1'b0, 8'hF1, 16'h00C6},  // R7 apply and lock
    {1'b1, 1'b0, 8'hF1, 16'h00C6},  // R7
    {1'b0, 1'b0, 8'hF1, 16'h0041},  // R8 rejected
    {1'b1, 1'b0, 8'hF1, 16'h00C6},  // R8
    {1'b0, 1'b0, 8'hF1, 16'h0038},  // R8 plain bits still writable
    {1'b1, 1'b0, 8'hF1, 16'h00FE},  // R8
    {1'b0, 1'b1, 8'hF0, 16'h0101},  // R8 word write, locked field holds
    {1'b1, 1'b1, 8'hF0, 16'hC601},  // R8
    {1'b0, 1'b0, 8'hE0, 16'h00FF},  // R1 out of window
    {1'b1, 1'b0, 8'hE0, 16'h0000},  // R1
    {1'b1, 1'b1, 8'hF0, 16'hC601}   // R1 unchanged
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic word, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_word = word; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic word, input logic [7:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_word = word; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, exp);
    check({req, " rvalid"}, {15'd0, bus_rvalid}, 16'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R3 reset state on outputs
    check("R3 trim0", {8'd0, trim0_o}, 16'h005A);
    check("R3 trim1", {8'd0, trim1_o}, 16'h0014);
    check("R3 trim3", {8'd0, trim3_o}, 16'h00A5);
    rst = 1'b0;
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][25]) do_rd(VEC[k][24], VEC[k][23:16], VEC[k][15:0], $sformatf("vector %0d", k));
      else            do_wr(VEC[k][24], VEC[k][23:16], VEC[k][15:0]);
    end
    // R10 outputs mirror registers
    check("R10 trim0", {8'd0, trim0_o}, 16'h0001);
    check("R10 trim1", {8'd0, trim1_o}, 16'h00C6);
    check("R10 trim3", {8'd0, trim3_o}, 16'h0077);
    // R4 low-power toggling retains contents
    @(negedge clk); lowpwr_i = 1'b1;
    repeat (5) @(negedge clk);
    lowpwr_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 trim0", {8'd0, trim0_o}, 16'h0001);
    check("R4 trim1", {8'd0, trim1_o}, 16'h00C6);
    do_rd(1'b1, 8'hF2, 16'h7700, "R4 word read");
    // R9 read and write in the same cycle returns old contents
    @(negedge clk);
    bus_rd = 1'b1; bus_wr = 1'b1; bus_word = 1'b0; bus_addr = 8'hF0; bus_wdata = 16'h0099;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    check("R9 read-before-write", bus_rdata, 16'h0001);
    do_rd(1'b0, 8'hF0, 16'h0099, "R9 after write");
    @(negedge clk);
    check("R9 rvalid drops", {15'd0, bus_rvalid}, 16'd0);
    // R8 reset clears lock, R3 defaults return
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R3 trim1 after reset", {8'd0, trim1_o}, 16'h0014);
    check("R3 trim3 after reset", {8'd0, trim3_o}, 16'h00A5);
    do_wr(1'b0, 8'hF1, 16'h0041);
    do_rd(1'b0, 8'hF1, 16'h0041, "R8 unlocked after reset");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule